// File: doc/BRIEF.md
# Logic Self-Test Sequencing Controller

This block runs a logic built-in self-test made of several segments, each divided into a fixed number of test intervals. A start request launches a run with settings sampled at that moment. The settings are how many intervals to execute, whether to begin again at the first interval of a chosen segment or carry on after the last finished interval, and how segment 0 treats the two processor cores: both at once, or only one of them. For each interval the controller raises a run request to an external pattern engine and waits for its completion strobe. It then compares each participating core's compacted signature with a golden value.

A run stops at the first signature mismatch, when the programmed number of intervals has passed, or when the last interval of the last segment has passed, whichever comes first. Every ending raises a core-only reset request for a fixed eight cycles, and a done flag rises with it. After that reset the cores restart from address zero. Pass/fail status, the failing segment and the per-core failure bits are only touched by the system reset and by later runs, so software can read them once it is running again. A diagnostic mode flips one signature bit of each participating core, so that the comparator's ability to catch a failure can be proven. Software arms this mode with an enable bit plus a 4-bit key.

Top module: `lbist_seq`

## Requirements
- R1: While and right after system reset, engRun, coreRstReq, done, testFail, coreFail and failSeg are all zero.
- R2: An accepted start raises engRun on the clock edge that samples it. The engine is told the segment in engSeg and the cores under test in engCoreMask (bit 0 = core 0, bit 1 = core 1). In segment 0, cfgCoreSel 2'b01 selects only core 0, 2'b10 selects only core 1, and 2'b00 or 2'b11 selects both. Every other segment always tests both cores.
- R3: A run executes cfgIntervals intervals, and a value of 0 counts as 1. engRun stays high until engDone, then drops for exactly one cycle between intervals. After INTS_PER_SEG intervals of a segment the next segment follows.
- R4: A run that ends without a mismatch raises coreRstReq for exactly 8 cycles, starting on the edge that samples the final engDone. done rises on that same edge. testFail, coreFail and failSeg are cleared on that same edge.
- R5: A mismatch on any core under test ends the run at that interval, with no further interval started. On the same edge, coreRstReq starts its 8-cycle pulse, done is set and testFail is set. failSeg records the segment (2'b00 for segment 0, 2'b01 for segment 1). coreFail records which tested cores mismatched, and a core that is not under test is never compared.
- R6: The signature bit 0 of each core under test is inverted before the comparison only when cfgFaultEn is 1 and cfgKey equals 4'hA at the accepted start. Any other key leaves the comparison untouched.
- R7: Starting with cfgRestart=1 begins at the first interval of segment cfgSegLoad, and a value not below NUM_SEG selects segment 0. Starting with cfgRestart=0 continues with the interval after the last one that passed. A run also ends after the last interval of the last segment, and a continue after that begins at segment 0.
- R8: startReq is ignored while a run or its reset pulse is in progress. No run is queued by it.
- R9: testFail, coreFail and failSeg are not changed by the end of the core reset pulse. They change only at system reset or at the end of a later run.
- R10: done is cleared on the edge that accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| startReq | input | 1 | Start pulse, accepted only when idle |
| cfgRestart | input | 1 | 1: begin at first interval of cfgSegLoad; 0: continue |
| cfgSegLoad | input | SEG_ID_W | Segment to begin in on a restart |
| cfgIntervals | input | CNT_W | Intervals to execute (0 treated as 1) |
| cfgCoreSel | input | 2 | Segment 0 core choice |
| cfgKey | input | 4 | Fault-insertion key |
| cfgFaultEn | input | 1 | Fault-insertion enable |
| engRun | output | 1 | Interval run request to the pattern engine |
| engSeg | output | SEG_ID_W | Segment of the current interval |
| engCoreMask | output | 2 | Cores under test |
| engDone | input | 1 | Interval complete, signatures valid |
| coreSig | input | 2*SIG_W | Signatures, core 1 in upper half |
| goldenSig | input | SIG_W | Expected signature |
| coreRstReq | output | 1 | Core-only reset request |
| done | output | 1 | Run finished |
| testFail | output | 1 | Last finished run failed |
| coreFail | output | 2 | Per-core failure bits |
| failSeg | output | SEG_ID_W | Segment of the failure |

## Verification
engRun is due on the edge that samples startReq, and it is due again one edge after a non-final engDone. coreRstReq, done and every status output change on the edge that samples the final or mismatching engDone. The bench drives its inputs on falling edges and reads each result on the falling edge right after the rising edge where that result is due. The reset pulse is counted one falling edge at a time, and the gap between intervals is checked on two falling edges in a row.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  localparam logic [3:0] ARM_KEY       = 4'hA;
  localparam int         RST_PULSE_CYC = 8;
  localparam int         NUM_CORES     = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP,
    ST_RST
  } lbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // start accepted this cycle
    logic advPtr;   // interval passed, step the pointer
    logic logFail;  // mismatch, capture failure status
    logic logPass;  // final interval passed, clear status
  } lbStrobe_t;

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RST_CYC = RST_PULSE_CYC
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] cfgIntervals,
  input  logic             engDone,
  input  logic             mismatch,
  input  logic             ptrAtEnd,
  output lbStrobe_t        strb,
  output logic             engRun,
  output logic             coreRstReq,
  output logic             done
);

  localparam int RC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  lbState_e         state, nextState;
  logic [CNT_W-1:0] remaining;
  logic [RC_W-1:0]  rstCnt;
  logic             accept, finishing, lastInt, passInt, failInt;

  assign accept    = startReq && (state == ST_IDLE);
  assign lastInt   = (remaining == CNT_W'(1)) || ptrAtEnd;
  assign passInt   = (state == ST_RUN) && engDone && !mismatch;
  assign failInt   = (state == ST_RUN) && engDone && mismatch;
  assign finishing = failInt || (passInt && lastInt);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (accept) nextState = ST_RUN;
      ST_RUN: begin
        if (finishing)    nextState = ST_RST;
        else if (passInt) nextState = ST_GAP;
      end
      ST_GAP:  nextState = ST_RUN;
      ST_RST:  if (rstCnt == RC_W'(RST_CYC - 1)) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      remaining <= '0;
      rstCnt    <= '0;
      done      <= 1'b0;
    end else begin
      state <= nextState;
      if (accept)
        remaining <= (cfgIntervals == '0) ? CNT_W'(1) : cfgIntervals;
      else if (passInt)
        remaining <= remaining - CNT_W'(1);
      if (state == ST_RST) rstCnt <= rstCnt + RC_W'(1);
      else                 rstCnt <= '0;
      if (finishing)   done <= 1'b1;
      else if (accept) done <= 1'b0;
    end
  end

  always_comb begin
    strb.launch  = accept;
    strb.advPtr  = passInt;
    strb.logFail = failInt;
    strb.logPass = passInt && lastInt;
  end

  assign engRun     = (state == ST_RUN);
  assign coreRstReq = (state == ST_RST);

endmodule

// File: rtl/lbist_dpath.sv
module lbist_dpath
  import lbist_pkg::*;
#(
  parameter int NUM_SEG      = 2,
  parameter int INTS_PER_SEG = 4,
  parameter int SEG_ID_W     = 2,
  parameter int SIG_W        = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  lbStrobe_t                  strb,
  input  logic                       cfgRestart,
  input  logic [SEG_ID_W-1:0]        cfgSegLoad,
  input  logic [1:0]                 cfgCoreSel,
  input  logic [3:0]                 cfgKey,
  input  logic                       cfgFaultEn,
  input  logic [NUM_CORES*SIG_W-1:0] coreSig,
  input  logic [SIG_W-1:0]           goldenSig,
  output logic                       mismatch,
  output logic                       ptrAtEnd,
  output logic [SEG_ID_W-1:0]        engSeg,
  output logic [NUM_CORES-1:0]       engCoreMask,
  output logic                       testFail,
  output logic [NUM_CORES-1:0]       coreFail,
  output logic [SEG_ID_W-1:0]        failSeg
);

  localparam int INT_W = (INTS_PER_SEG > 1) ? $clog2(INTS_PER_SEG) : 1;
  localparam logic [SEG_ID_W:0]   SEG_LIMIT = (SEG_ID_W + 1)'(NUM_SEG);
  localparam logic [SEG_ID_W-1:0] LAST_SEG  = SEG_ID_W'(NUM_SEG - 1);
  localparam logic [INT_W-1:0]    LAST_INT  = INT_W'(INTS_PER_SEG - 1);

  logic [SEG_ID_W-1:0]  curSeg;
  logic [INT_W-1:0]     curInt;
  logic [1:0]           coreSelQ;
  logic                 armQ;
  logic [NUM_CORES-1:0] miss;
  logic [SEG_ID_W-1:0]  segStart;

  assign segStart = ({1'b0, cfgSegLoad} < SEG_LIMIT) ? cfgSegLoad : '0;
  assign ptrAtEnd = (curSeg == LAST_SEG) && (curInt == LAST_INT);

  // interval pointer and per-run settings
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSeg   <= '0;
      curInt   <= '0;
      coreSelQ <= 2'b00;
      armQ     <= 1'b0;
    end else begin
      if (strb.launch) begin
        coreSelQ <= cfgCoreSel;
        armQ     <= cfgFaultEn && (cfgKey == ARM_KEY);
        if (cfgRestart) begin
          curSeg <= segStart;
          curInt <= '0;
        end
      end else if (strb.advPtr) begin
        if (curInt == LAST_INT) begin
          curInt <= '0;
          curSeg <= (curSeg == LAST_SEG) ? '0 : curSeg + SEG_ID_W'(1);
        end else begin
          curInt <= curInt + INT_W'(1);
        end
      end
    end
  end

  // segment 0 honours the core choice, other segments test both cores
  always_comb begin
    engCoreMask = '1;
    if (curSeg == '0) begin
      unique case (coreSelQ)
        2'b01:   engCoreMask = 2'b01;
        2'b10:   engCoreMask = 2'b10;
        default: engCoreMask = 2'b11;
      endcase
    end
  end

  assign engSeg = curSeg;

  // one comparator per core, fault flip on bit 0 when armed
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [SIG_W-1:0] sigEff;
    assign sigEff  = coreSig[c*SIG_W +: SIG_W] ^ SIG_W'(armQ && engCoreMask[c]);
    assign miss[c] = engCoreMask[c] && (sigEff != goldenSig);
  end

  assign mismatch = |miss;

  // status: kept across the core reset, only system reset or a run end touches it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testFail <= 1'b0;
      coreFail <= '0;
      failSeg  <= '0;
    end else if (strb.logFail) begin
      testFail <= 1'b1;
      coreFail <= miss;
      failSeg  <= curSeg;
    end else if (strb.logPass) begin
      testFail <= 1'b0;
      coreFail <= '0;
      failSeg  <= '0;
    end
  end

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int NUM_SEG      = 2,
  parameter int INTS_PER_SEG = 4,
  parameter int SEG_ID_W     = 2,
  parameter int CNT_W        = 8,
  parameter int SIG_W        = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                cfgRestart,
  input  logic [SEG_ID_W-1:0] cfgSegLoad,
  input  logic [CNT_W-1:0]    cfgIntervals,
  input  logic [1:0]          cfgCoreSel,
  input  logic [3:0]          cfgKey,
  input  logic                cfgFaultEn,
  output logic                engRun,
  output logic [SEG_ID_W-1:0] engSeg,
  output logic [1:0]          engCoreMask,
  input  logic                engDone,
  input  logic [2*SIG_W-1:0]  coreSig,
  input  logic [SIG_W-1:0]    goldenSig,
  output logic                coreRstReq,
  output logic                done,
  output logic                testFail,
  output logic [1:0]          coreFail,
  output logic [SEG_ID_W-1:0] failSeg
);

  lbStrobe_t strb;
  logic      mismatch, ptrAtEnd;

  lbist_ctrl #(.CNT_W(CNT_W), .RST_CYC(RST_PULSE_CYC)) u_ctrl (
    .clk, .rstN, .startReq, .cfgIntervals, .engDone,
    .mismatch, .ptrAtEnd, .strb, .engRun, .coreRstReq, .done
  );

  lbist_dpath #(
    .NUM_SEG(NUM_SEG), .INTS_PER_SEG(INTS_PER_SEG),
    .SEG_ID_W(SEG_ID_W), .SIG_W(SIG_W)
  ) u_dpath (
    .clk, .rstN, .strb, .cfgRestart, .cfgSegLoad, .cfgCoreSel,
    .cfgKey, .cfgFaultEn, .coreSig, .goldenSig, .mismatch, .ptrAtEnd,
    .engSeg, .engCoreMask, .testFail, .coreFail, .failSeg
  );

endmodule

// File: rtl/lbist_seq_chk.sv
module lbist_seq_chk #(
  parameter int SEG_ID_W = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                engRun,
  input logic                engDone,
  input logic [SEG_ID_W-1:0] engSeg,
  input logic [1:0]          engCoreMask,
  input logic                coreRstReq,
  input logic                done,
  input logic                testFail,
  input logic [1:0]          coreFail
);

  logic [4:0] rstLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rstLen <= '0;
    else if (coreRstReq) rstLen <= rstLen + 5'd1;
    else                 rstLen <= '0;
  end

  a_r4_rst_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreRstReq) |-> (rstLen == 5'(lbist_pkg::RST_PULSE_CYC)));

  a_r4_done_with_rst: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreRstReq) |-> done);

  a_r2_run_rst_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(engRun && coreRstReq));

  a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    engRun |-> (engCoreMask != 2'b00));

  a_r3_seg_stable: assert property (@(posedge clk) disable iff (!rstN)
    (engRun && $past(engRun)) |-> $stable(engSeg));

  a_r3_hold_run: assert property (@(posedge clk) disable iff (!rstN)
    (engRun && !engDone) |=> engRun);

  a_r5_fail_with_rst: assert property (@(posedge clk) disable iff (!rstN)
    $rose(testFail) |-> $rose(coreRstReq));

  a_r5_corefail_flag: assert property (@(posedge clk) disable iff (!rstN)
    (coreFail != 2'b00) |-> testFail);

  a_r8_no_run_after_rst: assert property (@(posedge clk) disable iff (!rstN)
    coreRstReq |=> !engRun);

  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(engRun) |-> !done);

endmodule

bind lbist_seq lbist_seq_chk #(.SEG_ID_W(SEG_ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .engRun(engRun), .engDone(engDone),
  .engSeg(engSeg), .engCoreMask(engCoreMask), .coreRstReq(coreRstReq),
  .done(done), .testFail(testFail), .coreFail(coreFail)
);

// File: tb/sim_lbist_seq.sv
module sim_lbist_seq;

  localparam int CLK_PERIOD = 10;
  localparam int SEG_ID_W   = 2;
  localparam int CNT_W      = 8;
  localparam int SIG_W      = 16;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                startReq = 1'b0;
  logic                cfgRestart = 1'b0;
  logic [SEG_ID_W-1:0] cfgSegLoad = '0;
  logic [CNT_W-1:0]    cfgIntervals = '0;
  logic [1:0]          cfgCoreSel = '0;
  logic [3:0]          cfgKey = '0;
  logic                cfgFaultEn = 1'b0;
  logic                engDone = 1'b0;
  logic [2*SIG_W-1:0]  coreSig = '0;
  logic [SIG_W-1:0]    goldenSig = 16'h5A3C;
  logic                engRun, coreRstReq, done, testFail;
  logic [SEG_ID_W-1:0] engSeg, failSeg;
  logic [1:0]          engCoreMask, coreFail;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lbist_seq u0 (
    .clk, .rstN, .startReq, .cfgRestart, .cfgSegLoad, .cfgIntervals,
    .cfgCoreSel, .cfgKey, .cfgFaultEn, .engRun, .engSeg, .engCoreMask,
    .engDone, .coreSig, .goldenSig, .coreRstReq, .done, .testFail,
    .coreFail, .failSeg
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doStart(input bit rs, input int seg, input int n, input int sel,
                         input int key, input bit fe);
    cfgRestart   = rs;
    cfgSegLoad   = SEG_ID_W'(seg);
    cfgIntervals = CNT_W'(n);
    cfgCoreSel   = 2'(sel);
    cfgKey       = 4'(key);
    cfgFaultEn   = fe;
    startReq     = 1'b1;
    @(negedge clk);
    startReq     = 1'b0;
  endtask

  // wait for engRun, check segment/mask, answer with the given signatures
  task automatic serve(input logic [SIG_W-1:0] s0, input logic [SIG_W-1:0] s1,
                       input int expSeg, input int expMask, input string tag);
    int w = 0;
    while (!engRun && w < 50) begin w++; @(negedge clk); end
    chk(engRun == 1'b1, {tag, " engRun"}, int'(engRun), 1);
    chk(engSeg == SEG_ID_W'(expSeg), {tag, " engSeg"}, int'(engSeg), expSeg);
    chk(engCoreMask == 2'(expMask), {tag, " mask"}, int'(engCoreMask), expMask);
    @(negedge clk);
    coreSig = {s1, s0};
    engDone = 1'b1;
    @(negedge clk);
    engDone = 1'b0;
  endtask

  task automatic rstWidth(output int wd);
    wd = 0;
    while (coreRstReq && wd < 30) begin wd++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk(!engRun && !coreRstReq && !done, "R1 ctl outs", int'({engRun, coreRstReq, done}), 0);
    chk(!testFail && coreFail == 0 && failSeg == 0, "R1 status", int'({testFail, coreFail, failSeg}), 0);
  endtask

  task automatic t_pass_single();
    int wd;
    doStart(1, 0, 1, 0, 0, 0);
    chk(engRun == 1'b1, "R2 run after start", int'(engRun), 1);
    serve(goldenSig, goldenSig, 0, 3, "R2 seg0 par");
    chk(coreRstReq && done, "R4 rst+done", int'({coreRstReq, done}), 3);
    chk(!engRun, "R4 engRun low", int'(engRun), 0);
    rstWidth(wd);
    chk(wd == 8, "R4 pulse width", wd, 8);
    chk(!testFail, "R4 pass status", int'(testFail), 0);
  endtask

  task automatic t_fault_par();
    int wd;
    doStart(1, 0, 1, 0, 'hA, 1);
    serve(goldenSig, goldenSig, 0, 3, "R6 armed");
    chk(testFail && coreRstReq, "R6 armed fail", int'({testFail, coreRstReq}), 3);
    chk(coreFail == 2'b11, "R5 both cores", int'(coreFail), 3);
    chk(failSeg == 2'b00, "R5 failSeg 00", int'(failSeg), 0);
    rstWidth(wd);
    chk(wd == 8, "R5 pulse width", wd, 8);
    repeat (3) @(negedge clk);
    chk(testFail && coreFail == 2'b11, "R9 status kept", int'({testFail, coreFail}), 7);
  endtask

  task automatic t_fault_single();
    int wd;
    doStart(1, 0, 1, 1, 'hA, 1);
    serve(goldenSig, goldenSig, 0, 1, "R2 core0 only");
    chk(coreFail == 2'b01, "R5 core0 fail", int'(coreFail), 1);
    rstWidth(wd);
    doStart(1, 0, 1, 2, 'hA, 1);
    serve(goldenSig, goldenSig, 0, 2, "R2 core1 only");
    chk(coreFail == 2'b10, "R5 core1 fail", int'(coreFail), 2);
    rstWidth(wd);
  endtask

  task automatic t_wrong_key();
    int wd;
    doStart(1, 0, 1, 0, 'h5, 1);
    chk(!done, "R10 done cleared", int'(done), 0);
    serve(goldenSig, goldenSig, 0, 3, "R6 bad key");
    chk(!testFail && coreFail == 0, "R6 bad key pass", int'({testFail, coreFail}), 0);
    chk(coreRstReq, "R4 pass rst", int'(coreRstReq), 1);
    rstWidth(wd);
  endtask

  task automatic t_seg1_fault();
    int wd;
    doStart(1, 1, 1, 1, 'hA, 1);
    serve(goldenSig, goldenSig, 1, 3, "R2 seg1 both");
    chk(failSeg == 2'b01, "R5 failSeg 01", int'(failSeg), 1);
    chk(coreFail == 2'b11, "R5 seg1 cores", int'(coreFail), 3);
    rstWidth(wd);
  endtask

  task automatic t_count_zero();
    int wd;
    doStart(1, 0, 0, 0, 0, 0);
    serve(goldenSig, goldenSig, 0, 3, "R3 count0");
    chk(coreRstReq, "R3 count0 ends", int'(coreRstReq), 1);
    rstWidth(wd);
  endtask

  task automatic t_multi();
    int wd;
    doStart(1, 0, 6, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      serve(goldenSig, goldenSig, (i < 4) ? 0 : 1, 3, "R3 multi");
      if (i < 5) begin
        chk(!engRun && !coreRstReq, "R3 gap low", int'(engRun), 0);
        @(negedge clk);
        chk(engRun, "R3 gap one cycle", int'(engRun), 1);
      end
    end
    chk(coreRstReq, "R3 end after 6", int'(coreRstReq), 1);
    rstWidth(wd);
  endtask

  task automatic t_continue_end();
    int wd;
    // pointer sits at segment 1 interval 2: only two intervals remain
    doStart(0, 0, 5, 0, 0, 0);
    serve(goldenSig, goldenSig, 1, 3, "R7 continue");
    @(negedge clk);
    serve(goldenSig, goldenSig, 1, 3, "R7 last int");
    chk(coreRstReq, "R7 stop at last", int'(coreRstReq), 1);
    rstWidth(wd);
    doStart(0, 1, 1, 0, 0, 0);
    chk(engSeg == 0, "R7 wrap seg0", int'(engSeg), 0);
    serve(goldenSig, goldenSig, 0, 3, "R7 wrap");
    rstWidth(wd);
    doStart(1, 3, 1, 0, 0, 0);
    chk(engSeg == 0, "R7 preload clamp", int'(engSeg), 0);
    serve(goldenSig, goldenSig, 0, 3, "R7 clamp");
    rstWidth(wd);
  endtask

  task automatic t_mid_fail();
    int wd;
    doStart(1, 0, 3, 0, 0, 0);
    serve(goldenSig, goldenSig, 0, 3, "R5 mid 1");
    @(negedge clk);
    serve(goldenSig, goldenSig ^ 16'h0100, 0, 3, "R5 mid 2");
    chk(coreRstReq && testFail, "R5 mid stop", int'({coreRstReq, testFail}), 3);
    chk(coreFail == 2'b10, "R5 mid core1", int'(coreFail), 2);
    rstWidth(wd);
    repeat (4) begin
      chk(!engRun, "R5 no third interval", int'(engRun), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy();
    int wd;
    doStart(1, 0, 1, 0, 0, 0);
    cfgRestart = 1'b1; cfgSegLoad = 2'd1; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    serve(goldenSig, goldenSig, 0, 3, "R8 busy run");
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    rstWidth(wd);
    repeat (4) begin
      chk(!engRun, "R8 start ignored", int'(engRun), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass_single();
    t_fault_par();
    t_fault_single();
    t_wrong_key();
    t_seg1_fault();
    t_count_zero();
    t_multi();
    t_continue_end();
    t_mid_fail();
    t_busy();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule